// File: doc/BRIEF.md
# Link-Based Reconfiguration Sequencer

This block masters a small 32-bit configuration-register bus and walks the full handshake that brings a target device's control block through a reconfiguration. It checks that reconfiguration is enabled, selects the link clock, enters reconfiguration mode, requests configuration, waits for readiness and starts the transfer. It then hands the bitstream phase to an external streamer. Afterwards it tears the session down, checks for a latched error and returns the device to user mode.

A single `start_i` pulse launches a run. Two image-type flags choose the number of clocks per data word used while streaming. Every register update is a read-modify-write issued through a valid/ready request channel with at most one request outstanding. Each request, read or write, is answered by exactly one `rsp_valid_i` pulse. That pulse comes no earlier than the cycle after acceptance. The requester holds `req_valid_o` and its fields steady until `req_ready_i` is seen, so the target may stall it for any number of cycles. When the run ends, `done_o` pulses and `err_o` holds the outcome until the next run.

Target register offsets: status 0x1C, mode control 0x20, data 0x28, program control 0x2C, latched error 0x34.

Top module: `rcfg_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `req_valid_o` and `strm_start_o` are 0 and `err_o` is 0 (no error).
- R2: A request keeps `req_valid_o`, `req_write_o`, `req_addr_o` and `req_wdata_o` unchanged until accepted. No new request is raised until the previous one has been answered on `rsp_valid_i`.
- R3: A run first reads status (0x1C). If bit 20 (enable) is 0, the run ends with `err_o` = 1 (no device) and issues no write.
- R4: If status bit 18 (ready) is already 1 at start, the teardown sequence runs before mode entry. The first write of the run then goes to program control (0x2C).
- R5: Clock select (bit 1 of 0x20) is set by one write, and mode enable (bit 0 of 0x20) is set by a later write. Mode enable never becomes 1 while clock select is 0.
- R6: A clock switch writes 1 into bits 15:8 of 0x20 and then issues `DUMMY_WRITES` writes to 0x28. Every data-register write occurs while that field is 1. A clean run performs three clock switches, and four when R4 applies.
- R7: The streaming clock count in bits 15:8 of 0x20 is 8 if the image is compressed, 4 if it is encrypted only, and 1 otherwise. It is written before the streamer is started. Bits 1:0 of 0x2C (config request, start transfer) are both 1 at that point.
- R8: `strm_start_o` pulses once per successful handshake. The sequencer waits for `strm_done_i` before teardown.
- R9: The ready poll reads 0x1C up to `READY_TRIES` times, with a gap of `POLL_GAP` idle cycles between reads. If bit 18 never reaches the wanted value, the run ends with `err_o` = 2.
- R10: After teardown, if bit 5 of 0x34 is 1, the run ends with `err_o` = 3 and mode bits 1:0 of 0x20 are left set.
- R11: Otherwise bits 1:0 of 0x20 are cleared and 0x1C is polled until bits 24 and 21 are both 1. The poll makes at most `USER_TRIES` reads, and a failure ends with `err_o` = 4. Success ends with `err_o` = 0.
- R12: `done_o` is a one-cycle pulse in the cycle `busy_o` falls. `err_o` is stable between runs. A `start_i` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, honoured only when idle |
| img_compressed_i | input | 1 | Image is compressed (sampled at launch) |
| img_encrypted_i | input | 1 | Image is encrypted (sampled at launch) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 3 | 0 ok, 1 no device, 2 ready timeout, 3 protocol error, 4 user-mode timeout |
| req_valid_o | output | 1 | Register request valid |
| req_ready_i | input | 1 | Target accepts request |
| req_write_o | output | 1 | 1 write, 0 read |
| req_addr_o | output | 8 | Register offset |
| req_wdata_o | output | 32 | Write data |
| rsp_valid_i | input | 1 | Response for the outstanding request |
| rsp_rdata_i | input | 32 | Read data with the response |
| strm_start_o | output | 1 | Pulse: streamer may send the bitstream |
| strm_done_i | input | 1 | Pulse: streamer has finished |

## Verification
The assertions assume that the target answers only a request it has accepted, with a single response pulse. They also assume that the streamer raises `strm_done_i` only after `strm_start_o`. The bench's target model produces the response exactly one cycle after acceptance and withholds `req_ready_i` in a repeating pattern, so every stall path is exercised without a spurious response. The streamer model answers a fixed number of cycles after each start pulse, and a deliberate start pulse during a run checks that the sequencer is not disturbed.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] A_STAT = 8'h1C;
  localparam logic [AW-1:0] A_MODE = 8'h20;
  localparam logic [AW-1:0] A_DATA = 8'h28;
  localparam logic [AW-1:0] A_PROG = 8'h2C;
  localparam logic [AW-1:0] A_LERR = 8'h34;

  localparam int unsigned B_READY = 18;
  localparam int unsigned B_EN    = 20;
  localparam int unsigned B_USER  = 21;
  localparam int unsigned B_FCLK  = 24;
  localparam int unsigned B_LERR  = 5;

  localparam logic [DW-1:0] CLK_FIELD = 32'h0000_FF00;
  localparam logic [DW-1:0] CLK_ONE   = 32'h0000_0100;

  typedef enum logic [2:0] {
    ERR_NONE, ERR_NODEV, ERR_RDY_TO, ERR_PROTO, ERR_USR_TO
  } err_e;

  typedef enum logic [2:0] {
    OP_CHKEN, OP_RMW, OP_DUMMY, OP_POLL, OP_CHKLAT, OP_STREAM, OP_END
  } op_e;

  // For OP_POLL, clr is the compare mask and set the wanted value.
  typedef struct packed {
    op_e           op;
    logic [AW-1:0] addr;
    logic [DW-1:0] clr;
    logic [DW-1:0] set;
    logic          ratio;
    logic          usr;
  } step_t;

  localparam int unsigned SW = 5;
  localparam logic [SW-1:0] MAIN_START = 5'd6;

  function automatic step_t mk(op_e op, logic [AW-1:0] a, logic [DW-1:0] c,
                               logic [DW-1:0] s, logic r, logic u);
    step_t t;
    t.op = op; t.addr = a; t.clr = c; t.set = s; t.ratio = r; t.usr = u;
    return t;
  endfunction

  function automatic step_t step_at(logic [SW-1:0] i);
    case (i)
      5'd0:  return mk(OP_CHKEN,  A_STAT, '0, '0, 1'b0, 1'b0);
      // early teardown, entered only when ready is already up
      5'd1:  return mk(OP_RMW,    A_PROG, 32'h2, '0, 1'b0, 1'b0);
      5'd2:  return mk(OP_RMW,    A_PROG, 32'h1, '0, 1'b0, 1'b0);
      5'd3:  return mk(OP_RMW,    A_MODE, CLK_FIELD, CLK_ONE, 1'b0, 1'b0);
      5'd4:  return mk(OP_DUMMY,  A_DATA, '0, '0, 1'b0, 1'b0);
      5'd5:  return mk(OP_POLL,   A_STAT, 32'(1) << B_READY, '0, 1'b0, 1'b0);
      // mode entry: clock select strictly before mode enable
      5'd6:  return mk(OP_RMW,    A_MODE, '0, 32'h2, 1'b0, 1'b0);
      5'd7:  return mk(OP_RMW,    A_MODE, '0, 32'h1, 1'b0, 1'b0);
      5'd8:  return mk(OP_RMW,    A_MODE, CLK_FIELD, CLK_ONE, 1'b0, 1'b0);
      5'd9:  return mk(OP_DUMMY,  A_DATA, '0, '0, 1'b0, 1'b0);
      5'd10: return mk(OP_RMW,    A_PROG, '0, 32'h1, 1'b0, 1'b0);
      5'd11: return mk(OP_POLL,   A_STAT, 32'(1) << B_READY, 32'(1) << B_READY, 1'b0, 1'b0);
      5'd12: return mk(OP_RMW,    A_MODE, CLK_FIELD, CLK_ONE, 1'b0, 1'b0);
      5'd13: return mk(OP_DUMMY,  A_DATA, '0, '0, 1'b0, 1'b0);
      5'd14: return mk(OP_RMW,    A_PROG, '0, 32'h2, 1'b0, 1'b0);
      5'd15: return mk(OP_RMW,    A_MODE, CLK_FIELD, '0, 1'b1, 1'b0);
      5'd16: return mk(OP_STREAM, A_DATA, '0, '0, 1'b0, 1'b0);
      // closing teardown
      5'd17: return mk(OP_RMW,    A_PROG, 32'h2, '0, 1'b0, 1'b0);
      5'd18: return mk(OP_RMW,    A_PROG, 32'h1, '0, 1'b0, 1'b0);
      5'd19: return mk(OP_RMW,    A_MODE, CLK_FIELD, CLK_ONE, 1'b0, 1'b0);
      5'd20: return mk(OP_DUMMY,  A_DATA, '0, '0, 1'b0, 1'b0);
      5'd21: return mk(OP_POLL,   A_STAT, 32'(1) << B_READY, '0, 1'b0, 1'b0);
      5'd22: return mk(OP_CHKLAT, A_LERR, '0, '0, 1'b0, 1'b0);
      5'd23: return mk(OP_RMW,    A_MODE, 32'h3, '0, 1'b0, 1'b0);
      5'd24: return mk(OP_POLL,   A_STAT, (32'(1) << B_FCLK) | (32'(1) << B_USER),
                       (32'(1) << B_FCLK) | (32'(1) << B_USER), 1'b0, 1'b1);
      default: return mk(OP_END,  A_STAT, '0, '0, 1'b0, 1'b0);
    endcase
  endfunction
endpackage

// File: rtl/rcfg_cnt.sv
module rcfg_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (load)             q <= load_val;
    else if (dec && q != '0)   q <= q - W'(1);
  end
endmodule

// File: rtl/rcfg_bus_master.sv
module rcfg_bus_master
  import rcfg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          fin,
  output logic [DW-1:0] rdata,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i
);
  logic waiting;

  assign fin   = waiting && rsp_valid_i;
  assign rdata = rsp_rdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_o <= 1'b0;
      req_write_o <= 1'b0;
      req_addr_o  <= '0;
      req_wdata_o <= '0;
      waiting     <= 1'b0;
    end else begin
      if (req_valid_o && req_ready_i) begin
        req_valid_o <= 1'b0;
        waiting     <= 1'b1;
      end
      if (fin) waiting <= 1'b0;
      if (go) begin
        req_valid_o <= 1'b1;
        req_write_o <= wr;
        req_addr_o  <= addr;
        req_wdata_o <= wdata;
      end
    end
  end
endmodule

// File: rtl/rcfg_seq.sv
module rcfg_seq
  import rcfg_pkg::*;
#(
  parameter int unsigned POLL_GAP     = 16,
  parameter int unsigned READY_TRIES  = 8,
  parameter int unsigned USER_TRIES   = 64,
  parameter int unsigned DUMMY_WRITES = 244
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          img_compressed_i,
  input  logic          img_encrypted_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [2:0]    err_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic          req_write_o,
  output logic [AW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_rdata_i,
  output logic          strm_start_o,
  input  logic          strm_done_i
);
  localparam int unsigned TRY_MAX = (READY_TRIES > USER_TRIES) ? READY_TRIES : USER_TRIES;
  localparam int unsigned TRY_W   = $clog2(TRY_MAX + 1);
  localparam int unsigned GAP_W   = $clog2(POLL_GAP + 1);
  localparam int unsigned DMY_W   = $clog2(DUMMY_WRITES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_RD, ST_WR, ST_DUMMY, ST_GAP, ST_STREAM
  } st_e;

  st_e           st, st_n;
  logic [SW-1:0] step, step_n;
  logic [7:0]    ratio_q;
  err_e          err_q, fin_err;
  logic          polling_q, poll_n, fin, sstart;
  step_t         cur;

  logic          go, wr, bm_fin;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, bm_rdata, rmw_val;
  logic          match;

  logic             try_ld, try_dec, gap_ld, gap_dec, dmy_ld, dmy_dec;
  logic [TRY_W-1:0] try_val, try_q;
  logic [GAP_W-1:0] gap_q;
  logic [DMY_W-1:0] dmy_q;

  assign cur     = step_at(step);
  assign rmw_val = (bm_rdata & ~cur.clr) | (cur.ratio ? {16'h0, ratio_q, 8'h0} : cur.set);
  assign match   = (bm_rdata & cur.clr) == cur.set;

  always_comb begin
    st_n = st; step_n = step; poll_n = polling_q;
    go = 1'b0; wr = 1'b0; addr = cur.addr; wdata = '0;
    fin = 1'b0; fin_err = ERR_NONE; sstart = 1'b0;
    try_ld = 1'b0; try_val = '0; try_dec = 1'b0;
    gap_ld = 1'b0; gap_dec = 1'b0; dmy_ld = 1'b0; dmy_dec = 1'b0;
    case (st)
      ST_IDLE: if (start_i) begin st_n = ST_ISSUE; step_n = '0; poll_n = 1'b0; end
      ST_ISSUE: begin
        case (cur.op)
          OP_END:    fin = 1'b1;
          OP_STREAM: begin sstart = 1'b1; st_n = ST_STREAM; end
          OP_DUMMY:  begin dmy_ld = 1'b1; go = 1'b1; wr = 1'b1; addr = A_DATA; st_n = ST_DUMMY; end
          default: begin
            go = 1'b1; st_n = ST_RD;
            if (cur.op == OP_POLL && !polling_q) begin
              try_ld  = 1'b1;
              try_val = cur.usr ? TRY_W'(USER_TRIES - 1) : TRY_W'(READY_TRIES - 1);
              poll_n  = 1'b1;
            end
          end
        endcase
      end
      ST_RD: if (bm_fin) begin
        case (cur.op)
          OP_CHKEN: begin
            if (!bm_rdata[B_EN]) begin fin = 1'b1; fin_err = ERR_NODEV; end
            else begin step_n = bm_rdata[B_READY] ? 5'd1 : MAIN_START; st_n = ST_ISSUE; end
          end
          OP_RMW: begin go = 1'b1; wr = 1'b1; wdata = rmw_val; st_n = ST_WR; end
          OP_POLL: begin
            if (match) begin step_n = step + 1'b1; poll_n = 1'b0; st_n = ST_ISSUE; end
            else if (try_q == '0) begin fin = 1'b1; fin_err = cur.usr ? ERR_USR_TO : ERR_RDY_TO; end
            else begin try_dec = 1'b1; gap_ld = 1'b1; st_n = ST_GAP; end
          end
          OP_CHKLAT: begin
            if (bm_rdata[B_LERR]) begin fin = 1'b1; fin_err = ERR_PROTO; end
            else begin step_n = step + 1'b1; st_n = ST_ISSUE; end
          end
          default: st_n = ST_ISSUE;
        endcase
      end
      ST_WR: if (bm_fin) begin step_n = step + 1'b1; st_n = ST_ISSUE; end
      ST_DUMMY: if (bm_fin) begin
        if (dmy_q == DMY_W'(1)) begin step_n = step + 1'b1; st_n = ST_ISSUE; end
        else begin dmy_dec = 1'b1; go = 1'b1; wr = 1'b1; addr = A_DATA; end
      end
      ST_GAP: if (gap_q == '0) st_n = ST_ISSUE; else gap_dec = 1'b1;
      ST_STREAM: if (strm_done_i) begin step_n = step + 1'b1; st_n = ST_ISSUE; end
      default: st_n = ST_IDLE;
    endcase
    if (fin) st_n = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; step <= '0; ratio_q <= 8'd1; err_q <= ERR_NONE;
      polling_q <= 1'b0; busy_o <= 1'b0; done_o <= 1'b0; strm_start_o <= 1'b0;
    end else begin
      st <= st_n; step <= step_n; polling_q <= poll_n;
      done_o <= fin; strm_start_o <= sstart;
      if (st == ST_IDLE && start_i) begin
        busy_o  <= 1'b1;
        err_q   <= ERR_NONE;
        ratio_q <= img_compressed_i ? 8'd8 : (img_encrypted_i ? 8'd4 : 8'd1);
      end
      if (fin) begin busy_o <= 1'b0; err_q <= fin_err; end
    end
  end

  assign err_o = err_q;

  rcfg_bus_master u_bm (
    .clk, .rst_n, .go, .wr, .addr, .wdata, .fin(bm_fin), .rdata(bm_rdata),
    .req_valid_o, .req_ready_i, .req_write_o, .req_addr_o, .req_wdata_o,
    .rsp_valid_i, .rsp_rdata_i
  );

  rcfg_cnt #(.W(TRY_W)) u_try (.clk, .rst_n, .load(try_ld), .load_val(try_val), .dec(try_dec), .q(try_q));
  rcfg_cnt #(.W(GAP_W)) u_gap (.clk, .rst_n, .load(gap_ld), .load_val(GAP_W'(POLL_GAP)), .dec(gap_dec), .q(gap_q));
  rcfg_cnt #(.W(DMY_W)) u_dmy (.clk, .rst_n, .load(dmy_ld), .load_val(DMY_W'(DUMMY_WRITES)), .dec(dmy_dec), .q(dmy_q));
endmodule

// File: rtl/rcfg_seq_chk.sv
module rcfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [2:0]  err_o,
  input logic        req_valid_o,
  input logic        req_ready_i,
  input logic        req_write_o,
  input logic [7:0]  req_addr_o,
  input logic [31:0] req_wdata_o,
  input logic        rsp_valid_i,
  input logic        strm_start_o
);
  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (req_valid_o && req_ready_i) outst <= 1'b1;
    else if (rsp_valid_i) outst <= 1'b0;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o)
      && $stable(req_write_o) && $stable(req_wdata_o));

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    outst |-> !req_valid_o);

  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(err_o));

  assert_strm_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strm_start_o |-> busy_o && !req_valid_o);
endmodule

bind rcfg_seq rcfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
  .req_write_o(req_write_o), .req_addr_o(req_addr_o), .req_wdata_o(req_wdata_o),
  .rsp_valid_i(rsp_valid_i), .strm_start_o(strm_start_o)
);

// File: tb/rcfg_seq_tb.sv
module rcfg_seq_tb;
  localparam int GAP = 2, RT = 3, UT = 4, DWR = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, img_c = 1'b0, img_e = 1'b0;
  logic busy_o, done_o, req_valid_o, req_ready_i, req_write_o, strm_start_o;
  logic [2:0] err_o;
  logic [7:0] req_addr_o;
  logic [31:0] req_wdata_o, rsp_rdata_i;
  logic rsp_valid_i, strm_done_i;

  always #4 clk = ~clk;

  rcfg_seq #(.POLL_GAP(GAP), .READY_TRIES(RT), .USER_TRIES(UT), .DUMMY_WRITES(DWR)) u_dut (
    .clk, .rst_n, .start_i, .img_compressed_i(img_c), .img_encrypted_i(img_e),
    .busy_o, .done_o, .err_o, .req_valid_o, .req_ready_i, .req_write_o,
    .req_addr_o, .req_wdata_o, .rsp_valid_i, .rsp_rdata_i, .strm_start_o, .strm_done_i
  );

  // target knobs (written by tasks only)
  logic        kn_en, kn_lat, kn_uok, m_clr;
  int          kn_dly;
  logic [31:0] kn_pinit;
  // target state and metrics
  logic [31:0] m_mode, m_prog;
  int m_rcnt, cyc, n_dw, n_bad, n_wr, n_rd, rd_p, rd_m, n_strm, sdl;
  logic [7:0] first_wr, strm_clk;
  logic [1:0] strm_prog;
  logic order_bad, rdy, usr;
  logic [31:0] stat;

  assign rdy = m_prog[0] && (m_rcnt >= kn_dly);
  assign usr = kn_uok && (m_mode[1:0] == 2'b00);
  always_comb begin
    stat = '0; stat[18] = rdy; stat[20] = kn_en; stat[21] = usr; stat[24] = usr;
  end
  assign req_ready_i = (cyc % 3) != 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid_i <= req_valid_o && req_ready_i;
    strm_done_i <= (sdl == 1);
    if (strm_start_o) begin
      n_strm <= n_strm + 1; strm_clk <= m_mode[15:8]; strm_prog <= m_prog[1:0]; sdl <= 4;
    end else if (sdl != 0) sdl <= sdl - 1;
    if (m_clr) begin
      m_mode <= '0; m_prog <= kn_pinit; m_rcnt <= 0; n_dw <= 0; n_bad <= 0;
      n_wr <= 0; n_rd <= 0; rd_p <= 0; rd_m <= 0; n_strm <= 0; order_bad <= 1'b0;
      first_wr <= 8'h00; strm_clk <= 8'h00; strm_prog <= 2'b00;
    end else if (req_valid_o && req_ready_i) begin
      if (req_write_o) begin
        n_wr <= n_wr + 1;
        if (n_wr == 0) first_wr <= req_addr_o;
        case (req_addr_o)
          8'h20: begin
            if (req_wdata_o[0] && !m_mode[0] && !m_mode[1]) order_bad <= 1'b1;
            m_mode <= req_wdata_o; rd_m <= 0;
          end
          8'h2C: begin m_prog <= req_wdata_o; rd_p <= 0; if (!req_wdata_o[0]) m_rcnt <= 0; end
          8'h28: begin n_dw <= n_dw + 1; if (m_mode[15:8] != 8'd1) n_bad <= n_bad + 1; end
          default: ;
        endcase
      end else begin
        n_rd <= n_rd + 1;
        case (req_addr_o)
          8'h1C: begin
            rsp_rdata_i <= stat; rd_p <= rd_p + 1; rd_m <= rd_m + 1;
            if (m_prog[0] && !rdy) m_rcnt <= m_rcnt + 1;
          end
          8'h20: rsp_rdata_i <= m_mode;
          8'h2C: rsp_rdata_i <= m_prog;
          8'h34: rsp_rdata_i <= {26'h0, kn_lat, 5'h0};
          default: rsp_rdata_i <= '0;
        endcase
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  logic [2:0] got_err;
  task automatic run(input bit c, input bit e, input bit en, input int dly,
                     input logic [31:0] pinit, input bit lat, input bit uok, input bit poke);
    int t;
    bit poked;
    @(negedge clk);
    kn_en = en; kn_dly = dly; kn_pinit = pinit; kn_lat = lat; kn_uok = uok; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0; img_c = c; img_e = e; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t = 0; poked = 1'b0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
      start_i = 1'b0;
      if (poke && !poked && n_strm == 1) begin start_i = 1'b1; poked = 1'b1; end
    end
    start_i = 1'b0;
    chk(t < 20000, "WATCHDOG", t, 20000);
    got_err = err_o;
    @(negedge clk);
    chk(!done_o && !busy_o, "R12 done one-cycle pulse", int'(done_o), 0);
  endtask

  initial begin
    kn_en = 1'b1; kn_dly = 0; kn_pinit = '0; kn_lat = 1'b0; kn_uok = 1'b1; m_clr = 1'b1;
    cyc = 0; sdl = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !req_valid_o && !strm_start_o, "R1 outputs idle", int'(busy_o), 0);
    chk(err_o == 3'd0, "R1 err zero", int'(err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 sweep over image-type flags with a clean handshake
    for (int k = 0; k < 4; k++) begin
      automatic bit c = k[1];
      automatic bit e = k[0];
      automatic int ratio = c ? 8 : (e ? 4 : 1);
      run(c, e, 1'b1, 2, 32'h0, 1'b0, 1'b1, 1'b0);
      chk(got_err == 3'd0, "R11 success code", int'(got_err), 0);
      chk(int'(strm_clk) == ratio, "R7 streaming clock count", int'(strm_clk), ratio);
      chk(strm_prog == 2'b11, "R7 prog bits at handoff", int'(strm_prog), 3);
      chk(n_strm == 1, "R8 single streamer start", n_strm, 1);
      chk(n_dw == 3 * DWR, "R6 dummy write total", n_dw, 3 * DWR);
      chk(n_bad == 0, "R6 count field one during dummies", n_bad, 0);
      chk(!order_bad, "R5 clock select before mode", int'(order_bad), 0);
      chk(first_wr == 8'h20, "R4 no early teardown", int'(first_wr), 32);
      chk(m_mode[1:0] == 2'b00, "R11 mode bits cleared", int'(m_mode[1:0]), 0);
    end

    // R3 enable clear
    run(1'b0, 1'b0, 1'b0, 2, 32'h0, 1'b0, 1'b1, 1'b0);
    chk(got_err == 3'd1, "R3 no-device code", int'(got_err), 1);
    chk(n_wr == 0 && n_rd == 1, "R3 single read, no write", n_wr, 0);

    // R4 ready already up
    run(1'b0, 1'b1, 1'b1, 0, 32'h3, 1'b0, 1'b1, 1'b0);
    chk(got_err == 3'd0, "R4 run completes", int'(got_err), 0);
    chk(first_wr == 8'h2C, "R4 first write to program control", int'(first_wr), 44);
    chk(n_dw == 4 * DWR, "R6 four clock switches", n_dw, 4 * DWR);

    // R9 ready never rises
    run(1'b0, 1'b0, 1'b1, 1000, 32'h0, 1'b0, 1'b1, 1'b0);
    chk(got_err == 3'd2, "R9 ready timeout code", int'(got_err), 2);
    chk(rd_p == RT, "R9 ready poll read count", rd_p, RT);
    chk(n_strm == 0, "R9 no streamer start", n_strm, 0);

    // R10 latched error
    run(1'b1, 1'b0, 1'b1, 1, 32'h0, 1'b1, 1'b1, 1'b0);
    chk(got_err == 3'd3, "R10 protocol code", int'(got_err), 3);
    chk(m_mode[1:0] == 2'b11, "R10 mode bits kept", int'(m_mode[1:0]), 3);

    // R11 user mode never reached
    run(1'b0, 1'b0, 1'b1, 1, 32'h0, 1'b0, 1'b0, 1'b0);
    chk(got_err == 3'd4, "R11 user timeout code", int'(got_err), 4);
    chk(rd_m == UT, "R11 user poll read count", rd_m, UT);

    // R12 start while busy ignored, error held between runs
    run(1'b1, 1'b1, 1'b1, 1, 32'h0, 1'b0, 1'b1, 1'b1);
    chk(got_err == 3'd0 && int'(strm_clk) == 8, "R12 run undisturbed", int'(strm_clk), 8);
    repeat (20) @(negedge clk);
    chk(!busy_o && n_strm == 1, "R12 no second run", n_strm, 1);
    chk(err_o == 3'd0, "R12 code held", int'(err_o), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule